// File: doc/BRIEF.md
# User-Level Counter CSR Unit

This block keeps the unprivileged 64-bit counters of one processor core and answers read requests addressed to them. Slot 0 counts core clock cycles, slot 1 counts pulses of a fixed-rate real-time tick, slot 2 counts retired instructions, and a parameter-selected number of further slots each count pulses on one event line. Every counter is 64 bits wide, whatever the register width of the core.

A read request carries a 12-bit CSR address and a flag telling whether the instruction would also write. The unit decodes the address and registers a response in the cycle after the request: the full counter when the core is 64 bits wide, or one 32-bit half when it is 32 bits wide. It also raises a fault flag for any access the core must treat as an illegal instruction. A three-state response machine (RSP_IDLE, RSP_DATA, RSP_FAULT) holds the answer. A request with a legal decode takes the ACCEPT transition into RSP_DATA. A request with an illegal decode takes the REJECT transition into RSP_FAULT. A cycle with no request takes the DRAIN transition back to RSP_IDLE. Back-to-back requests move directly between RSP_DATA and RSP_FAULT, in either direction, without passing through idle.

Top module: `ucnt_csr_unit`

## Requirements
- R1: A read of address 0xC00 + i, for an implemented slot i, returns the full 64-bit count when XLEN is 64 and bits 31..0 when XLEN is 32.
- R2: When XLEN is 32, a read of address 0xC80 + i returns bits 63..32 of slot i, zero-extended into the response.
- R3: Slot 0 advances by one on every clock edge after reset is released.
- R4: Slot 1 advances by one on each clock edge where `tick_i` is high.
- R5: Slot 2 advances by one on each clock edge where `retire_i` is high.
- R6: Slot 3 + j advances by one on each clock edge where `evt_i[j]` is high, for j below NUM_EVT.
- R7: Each of the following gives a response with `rsp_fault_o` high and data zero: a slot index of 3 + NUM_EVT or more, the 0xC80 window when XLEN is 64, or an address outside both windows (address bits 11..5 equal neither 0x60 nor 0x64).
- R8: A request with `req_wr_i` high is faulted with zero data, and it leaves every counter unchanged.
- R9: A request sampled at a clock edge yields `rsp_valid_o` high for the next cycle only. The data is the counter value from before that edge's increment. With no request, the next cycle shows `rsp_valid_o`, `rsp_fault_o` and `rsp_data_o` all low.
- R10: Reset (asynchronous, active low) loads every counter with SEED, which is zero by default, and puts the response machine in RSP_IDLE with all outputs low.
- R11: A carry out of bit 31 reaches bit 32 on the same clock edge, so a read of either half never returns a torn value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Real-time tick pulse, one clock wide |
| retire_i | input | 1 | One instruction retired this cycle |
| evt_i | input | max(NUM_EVT,1) | Event pulses, bit j feeds slot 3 + j |
| req_i | input | 1 | Read request valid |
| req_addr_i | input | 12 | CSR address of the request |
| req_wr_i | input | 1 | Requesting instruction would write |
| rsp_valid_o | output | 1 | Response valid (one cycle after request) |
| rsp_fault_o | output | 1 | Illegal-instruction flag for the response |
| rsp_data_o | output | XLEN | Counter value or selected half |

## Verification
The hardest case to reach from the ports is a carry from the low half into the high half, because it needs four billion cycles from a zero reset. The unit has a SEED parameter, so the bench builds a second instance whose counters start sixteen counts below the 32-bit boundary. It then alternates reads of the low and high halves of slot 0 across the wrap, so a high half that lags by even one cycle shows up as a wrong value. A third instance is built with XLEN = 64 to check that the high window is faulted.

// File: rtl/ucnt_pkg.sv
`timescale 1ns/1ps
package ucnt_pkg;
    localparam int CSR_AW    = 12;
    localparam int CNT_W     = 64;
    localparam int NUM_SLOTS = 32;
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int FIXED     = 3;
    localparam int WIN_W     = CSR_AW - IDX_W;
    localparam logic [WIN_W-1:0] WIN_LO = 7'h60;
    localparam logic [WIN_W-1:0] WIN_HI = 7'h64;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/ucnt_counter64.sv
`timescale 1ns/1ps
module ucnt_counter64 #(
    parameter int                        LO_W = 32,
    parameter logic [ucnt_pkg::CNT_W-1:0] SEED = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc_i,
    output logic [ucnt_pkg::CNT_W-1:0]  value_o
);
    localparam int HI_W = ucnt_pkg::CNT_W - LO_W;

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            carry;

    // carry into the upper half is decided from the current lower half,
    // so both halves move on the same edge
    assign carry = inc_i & (&lo_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= SEED[LO_W-1:0];
            hi_q <= SEED[ucnt_pkg::CNT_W-1:LO_W];
        end else begin
            if (inc_i) lo_q <= lo_q + 1'b1;
            if (carry) hi_q <= hi_q + 1'b1;
        end
    end

    assign value_o = {hi_q, lo_q};
endmodule

// File: rtl/ucnt_decode.sv
`timescale 1ns/1ps
module ucnt_decode #(
    parameter int XLEN     = 32,
    parameter int NUM_IMPL = 3
) (
    input  logic [ucnt_pkg::CSR_AW-1:0] addr_i,
    input  logic                        wr_i,
    output logic [ucnt_pkg::IDX_W-1:0]  idx_o,
    output logic                        hi_o,
    output logic                        fault_o
);
    import ucnt_pkg::*;

    logic [WIN_W-1:0] win;
    logic             in_lo, in_hi, hi_ok, impl;

    assign win   = addr_i[CSR_AW-1:IDX_W];
    assign idx_o = addr_i[IDX_W-1:0];
    assign in_lo = (win == WIN_LO);
    assign in_hi = (win == WIN_HI);
    assign hi_ok = in_hi && (XLEN == 32);
    assign impl  = ({1'b0, idx_o} < (IDX_W+1)'(NUM_IMPL));
    assign hi_o  = in_hi;

    always_comb begin
        fault_o = 1'b0;
        if (wr_i)                 fault_o = 1'b1;
        else if (!(in_lo || hi_ok)) fault_o = 1'b1;
        else if (!impl)           fault_o = 1'b1;
    end
endmodule

// File: rtl/ucnt_rsp_fsm.sv
`timescale 1ns/1ps
module ucnt_rsp_fsm #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            fault_i,
    input  logic [XLEN-1:0] data_i,
    output logic            rsp_valid_o,
    output logic            rsp_fault_o,
    output logic [XLEN-1:0] rsp_data_o
);
    import ucnt_pkg::*;

    rsp_state_e state_q, state_d;
    logic [XLEN-1:0] data_q;

    // next state: ACCEPT, REJECT, DRAIN (and the chained moves between
    // DATA and FAULT on back-to-back requests)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: begin
                if (req_i) state_d = fault_i ? RSP_FAULT : RSP_DATA;
            end
            RSP_DATA: begin
                if (!req_i)      state_d = RSP_IDLE;
                else if (fault_i) state_d = RSP_FAULT;
                else             state_d = RSP_DATA;
            end
            RSP_FAULT: begin
                if (!req_i)      state_d = RSP_IDLE;
                else if (fault_i) state_d = RSP_FAULT;
                else             state_d = RSP_DATA;
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    // output register: data captured alongside the state move
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    data_q <= '0;
        else if (state_d == RSP_DATA)  data_q <= data_i;
        else                           data_q <= '0;
    end

    assign rsp_valid_o = (state_q != RSP_IDLE);
    assign rsp_fault_o = (state_q == RSP_FAULT);
    assign rsp_data_o  = data_q;
endmodule

// File: rtl/ucnt_csr_unit.sv
`timescale 1ns/1ps
module ucnt_csr_unit #(
    parameter int                        XLEN    = 32,
    parameter int                        NUM_EVT = 4,
    parameter logic [ucnt_pkg::CNT_W-1:0] SEED    = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_i,
    input  logic                              retire_i,
    input  logic [((NUM_EVT>0)?NUM_EVT:1)-1:0] evt_i,
    input  logic                              req_i,
    input  logic [11:0]                       req_addr_i,
    input  logic                              req_wr_i,
    output logic                              rsp_valid_o,
    output logic                              rsp_fault_o,
    output logic [XLEN-1:0]                   rsp_data_o
);
    import ucnt_pkg::*;

    localparam int NUM_IMPL = FIXED + NUM_EVT;
    localparam int HALF_W   = CNT_W / 2;

    logic [NUM_IMPL-1:0] inc_vec;
    logic [CNT_W-1:0]    cnt_val [NUM_SLOTS];
    logic [IDX_W-1:0]    idx;
    logic                sel_hi, fault;
    logic [CNT_W-1:0]    word;
    logic [XLEN-1:0]     rd_data;

    always_comb begin
        inc_vec    = '0;
        inc_vec[0] = 1'b1;
        inc_vec[1] = tick_i;
        inc_vec[2] = retire_i;
        for (int j = 0; j < NUM_EVT; j++) inc_vec[FIXED+j] = evt_i[j];
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g < NUM_IMPL) begin : g_impl
            ucnt_counter64 #(.LO_W(HALF_W), .SEED(SEED)) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .inc_i  (inc_vec[g]),
                .value_o(cnt_val[g])
            );
        end else begin : g_absent
            assign cnt_val[g] = '0;
        end
    end

    ucnt_decode #(.XLEN(XLEN), .NUM_IMPL(NUM_IMPL)) u_dec (
        .addr_i (req_addr_i),
        .wr_i   (req_wr_i),
        .idx_o  (idx),
        .hi_o   (sel_hi),
        .fault_o(fault)
    );

    assign word = cnt_val[idx];

    if (XLEN == 32) begin : g_x32
        assign rd_data = sel_hi ? word[CNT_W-1:HALF_W] : word[HALF_W-1:0];
    end else begin : g_x64
        // the upper window is faulted on a 64-bit core; keep its data at zero
        assign rd_data = word & {CNT_W{~sel_hi}};
    end

    ucnt_rsp_fsm #(.XLEN(XLEN)) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .fault_i    (fault),
        .data_i     (rd_data),
        .rsp_valid_o(rsp_valid_o),
        .rsp_fault_o(rsp_fault_o),
        .rsp_data_o (rsp_data_o)
    );
endmodule

// File: rtl/ucnt_csr_unit_chk.sv
`timescale 1ns/1ps
module ucnt_csr_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic [11:0]     req_addr_i,
    input logic            req_wr_i,
    input logic            rsp_valid_o,
    input logic            rsp_fault_o,
    input logic [XLEN-1:0] rsp_data_o
);
    logic rd_cyc_lo;
    assign rd_cyc_lo = req_i && !req_wr_i && (req_addr_i == 12'hC00);

    a_r9_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_valid_o);

    a_r9_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!rsp_valid_o && !rsp_fault_o && rsp_data_o == '0));

    a_r8_write_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && req_wr_i) |=> rsp_fault_o);

    a_r7_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_o |-> (rsp_valid_o && rsp_data_o == '0));

    a_r7_hi_window_x64: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && XLEN == 64 && req_addr_i[11:5] == 7'h64) |=> rsp_fault_o);

    a_r3_cycle_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc_lo && $past(rd_cyc_lo)) |=> (rsp_data_o == $past(rsp_data_o) + 1'b1));
endmodule

bind ucnt_csr_unit ucnt_csr_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/ucnt_csr_unit_bench.sv
`timescale 1ns/1ps
module ucnt_csr_unit_bench;
    localparam int          NEVT   = 2;
    localparam int          NIMPL  = 3 + NEVT;
    localparam logic [63:0] SEED_B = 64'h0000_0000_FFFF_FFF0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, retire = 1'b0;
    logic [NEVT-1:0] evt = '0;
    logic req = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;

    logic va, fa, vb, fb, vc, fc;
    logic [31:0] da, db;
    logic [63:0] dc;

    int n_chk = 0, n_bad = 0;
    bit carry_phase = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ucnt_csr_unit #(.XLEN(32), .NUM_EVT(NEVT)) u_ucnt_csr_unit (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .retire_i(retire), .evt_i(evt),
        .req_i(req), .req_addr_i(addr), .req_wr_i(wr),
        .rsp_valid_o(va), .rsp_fault_o(fa), .rsp_data_o(da));

    ucnt_csr_unit #(.XLEN(32), .NUM_EVT(NEVT), .SEED(SEED_B)) u_ucnt_csr_unit_seed (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .retire_i(retire), .evt_i(evt),
        .req_i(req), .req_addr_i(addr), .req_wr_i(wr),
        .rsp_valid_o(vb), .rsp_fault_o(fb), .rsp_data_o(db));

    ucnt_csr_unit #(.XLEN(64), .NUM_EVT(NEVT)) u_ucnt_csr_unit_x64 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .retire_i(retire), .evt_i(evt),
        .req_i(req), .req_addr_i(addr), .req_wr_i(wr),
        .rsp_valid_o(vc), .rsp_fault_o(fc), .rsp_data_o(dc));

    // bench model: event totals since reset
    logic [63:0] mc [NIMPL];
    bit          pend;
    logic        ef [3];
    logic [63:0] ed [3];
    string       etag [3];

    function automatic void expect_rsp(input int xlen, input logic [63:0] seed,
                                       input logic [11:0] a, input logic w,
                                       output logic f, output logic [63:0] d,
                                       output string tag);
        int idx = int'(a[4:0]);
        bit lo = (a[11:5] == 7'h60);
        bit hi = (a[11:5] == 7'h64);
        bit legal = !w && (lo || (hi && xlen == 32)) && idx < NIMPL;
        logic [63:0] v;
        f = !legal;
        d = '0;
        if (w)           tag = "R8";
        else if (!legal) tag = "R7";
        else begin
            v = seed + mc[idx];
            if (xlen == 64)  d = v;
            else if (hi)     d = {32'b0, v[63:32]};
            else             d = {32'b0, v[31:0]};
            case (idx)
                0: tag = "R3";
                1: tag = "R4";
                2: tag = "R5";
                default: tag = "R6";
            endcase
            if (hi) tag = {tag, " R2"};
            else    tag = {tag, " R1"};
            if (carry_phase) tag = {tag, " R11"};
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NIMPL; i++) mc[i] <= '0;
            pend <= 1'b0;
        end else begin
            logic f0, f1, f2;
            logic [63:0] d0, d1, d2;
            string t0, t1, t2;
            pend <= req;
            if (req) begin
                expect_rsp(32, 64'd0, addr, wr, f0, d0, t0);
                expect_rsp(32, SEED_B, addr, wr, f1, d1, t1);
                expect_rsp(64, 64'd0, addr, wr, f2, d2, t2);
                ef[0] <= f0; ed[0] <= d0; etag[0] <= t0;
                ef[1] <= f1; ed[1] <= d1; etag[1] <= t1;
                ef[2] <= f2; ed[2] <= d2; etag[2] <= t2;
            end
            mc[0] <= mc[0] + 64'd1;
            mc[1] <= mc[1] + {63'd0, tick};
            mc[2] <= mc[2] + {63'd0, retire};
            for (int j = 0; j < NEVT; j++) mc[3+j] <= mc[3+j] + {63'd0, evt[j]};
        end
    end

    task automatic check_one(input string inst, input int k, input logic v,
                             input logic f, input logic [63:0] d);
        n_chk++;
        if (!pend) begin
            if (v !== 1'b0 || f !== 1'b0 || d !== 64'd0) begin
                n_bad++;
                $display("FAIL R9 %s idle: valid=%b fault=%b data=%h expected 0/0/0",
                         inst, v, f, d);
            end
        end else if (v !== 1'b1 || f !== ef[k] || d !== ed[k]) begin
            n_bad++;
            $display("FAIL %s R9 %s: valid=%b fault=%b data=%h expected 1/%b/%h",
                     etag[k], inst, v, f, d, ef[k], ed[k]);
        end
    endtask

    bit checking = 1'b0;
    always @(negedge clk) begin
        if (checking) begin
            check_one("a",   0, va, fa, {32'b0, da});
            check_one("seed", 1, vb, fb, {32'b0, db});
            check_one("x64", 2, vc, fc, dc);
        end
    end

    // event stimulus pattern
    int k_cyc = 0;
    always @(negedge clk) begin
        k_cyc++;
        tick   <= (k_cyc % 5 == 0);
        retire <= (k_cyc % 3 != 0);
        evt    <= {(k_cyc % 7 == 1), k_cyc[0]};
    end

    task automatic issue(input logic [11:0] a, input logic w);
        @(negedge clk);
        req <= 1'b1; addr <= a; wr <= w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req <= 1'b0; wr <= 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet while reset holds
        n_chk++;
        if (va || fa || da != 0 || vb || fb || db != 0 || vc || fc || dc != 0) begin
            n_bad++;
            $display("FAIL R10 reset outputs: a=%b/%b/%h x64=%b/%b/%h expected all zero",
                     va, fa, da, vc, fc, dc);
        end
        @(negedge clk);
        rst_n <= 1'b1;
        checking <= 1'b1;
        // R10: first reads right after reset show the seeded/zero counters
        issue(12'hC02, 1'b0);
        issue(12'hC03, 1'b0);
        // R11: alternate halves of slot 0 across the 32-bit wrap of the seeded unit
        carry_phase = 1'b1;
        for (int i = 0; i < 40; i++) issue((i % 2 == 0) ? 12'hC80 : 12'hC00, 1'b0);
        for (int i = 0; i < 6; i++) issue(12'hC00, 1'b0);
        idle(1);
        carry_phase = 1'b0;
        // R1..R7: every address of the 0xC00..0xCFF block
        for (int a = 12'hC00; a <= 12'hCFF; a++) issue(12'(a), 1'b0);
        idle(2);
        // R7: addresses far outside the windows
        issue(12'h000, 1'b0); issue(12'hB00, 1'b0); issue(12'hFFF, 1'b0);
        issue(12'hC40, 1'b0); issue(12'h880, 1'b0);
        // R8: writes to both windows, then reads show counters untouched
        for (int i = 0; i < 32; i++) issue(12'(12'hC00 + i), 1'b1);
        for (int i = 0; i < 8; i++)  issue(12'(12'hC80 + i), 1'b1);
        for (int i = 0; i < NIMPL; i++) begin
            issue(12'(12'hC00 + i), 1'b0);
            issue(12'(12'hC80 + i), 1'b0);
        end
        // R9: sparse requests with gaps
        for (int i = 0; i < 20; i++) begin
            issue(12'(12'hC00 + (i % NIMPL)), 1'b0);
            idle(1 + (i % 3));
        end
        idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule